// File: doc/BRIEF.md
# Oscillator Command and Mode Controller

This block sits behind a single-wire receiver that has already turned line activity into whole bytes, setup-sequence pulses and raw line-edge pulses. It gathers each command code together with its argument bytes, runs the operating-mode state machine of a programmable clock source, and keeps the configuration it controls: base frequency, absolute frequency offset, output drive strength and a power/jitter selection. The frequency synthesiser and the power gating are not part of the block; it drives enables and a recalibration request/acknowledge handshake toward them.

Settings are staged. A new base frequency or a power/jitter choice written while the output is stopped or running is held pending and copied into the active registers only when the machine passes through frequency setup (or, for the offset, on a return to run). Every stop first finishes the clock period in progress: the clock enable falls at once, while the output keeps driving until the synthesiser reports a period boundary.

Top module: `osc_mode_ctrl`

## Requirements
- R1: After reset the block is in run (mode_code 0), with clk_en, out_drive, reso_en and core_en high, recal_req low, base_freq at DEF_FREQ, freq_offset 0, drive_sel at DEF_DRV and jitter_mode at DEF_PJ. mode_code reads 0 run, 1 drain, 2 frequency setup, 3 stop, 4 doze, 5 sleep.
- R2: Codes and argument counts are 0x50 run (0), 0x18 stop (0), 0x20 doze (0), 0x30 sleep (0), 0x0C new frequency (4), 0x10 factory frequency (0), 0x3A offset (2), 0x41 drive strength (1), 0x49 power/jitter (1), 0x00 no-op (0); arguments are most significant byte first, and a command acts only once its last argument byte has arrived.
- R3: An rx_setup pulse while arguments are outstanding discards the partial command, and the next byte is taken as a fresh command code.
- R4: A byte in the code position that is not in the R2 list raises cmd_error for exactly one cycle and changes no mode or setting.
- R5: Stop, doze or sleep received in run enters drain (clk_en low, out_drive high) and moves to the target mode on the cycle period_done is sampled; stop keeps reso_en and core_en high, doze keeps only core_en, sleep drops all three.
- R6: New frequency or factory frequency in run goes through drain to frequency setup, where recal_req is high, clk_en is low, the new base is active and the offset is zero; recal_ack returns the block to run with clk_en high on the next cycle.
- R7: In stop or doze a new frequency is only stored, the last one written wins, and a run command then goes through frequency setup to apply it.
- R8: The offset command replaces the offset absolutely; in run it is active at once, in stop or doze it becomes active on the next return to run.
- R9: A power/jitter write (argument bit 0: 0 low power, 1 low jitter) becomes active only on entry to frequency setup, which a run command issued in run also causes.
- R10: In sleep all bytes and setup pulses are ignored; a line_edge pulse returns the block directly to run with every setting retained.
- R11: Frequency setup leaves only to run; mode commands received there are ignored.
- R12: The drive strength command updates drive_sel at once in any mode but sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| rx_setup | input | 1 | One-cycle strobe: a setup sequence was received |
| line_edge | input | 1 | One-cycle strobe: an edge was seen on the line |
| period_done | input | 1 | Synthesiser reports the end of an output clock period |
| recal_ack | input | 1 | Synthesiser finished recalibration |
| clk_en | output | 1 | Output clock enable |
| out_drive | output | 1 | Output driver enable (low means tri-state) |
| reso_en | output | 1 | Resonator enable |
| core_en | output | 1 | Core power enable |
| recal_req | output | 1 | Recalibration request, held until acknowledged |
| mode_code | output | 3 | Current mode, encoded as in R1 |
| base_freq | output | FREQ_W | Active base frequency (single-precision value in Hz) |
| freq_offset | output | OFS_W | Active signed offset in 2^-25 steps |
| drive_sel | output | DRV_W | Active drive strength |
| jitter_mode | output | 1 | Active power/jitter selection |
| cmd_error | output | 1 | One-cycle flag for an unknown command code |

## Verification
The parser registers a finished command on the first rising edge that samples its last byte, so cmd_error is due one edge after that byte and mode and setting changes two edges after it. The period_done, recal_ack and line_edge strobes act on the very edge that samples them. The bench changes inputs at falling edges and reads outputs at the falling edge that follows the edge on which each result is due, so every check lands in the exact cycle the result first appears, and a stored-but-not-applied value is read in the cycles before the transition that applies it.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

   typedef enum logic [2:0] {
      M_RUN   = 3'd0,
      M_DRAIN = 3'd1,
      M_SETUP = 3'd2,
      M_STOP  = 3'd3,
      M_DOZE  = 3'd4,
      M_SLEEP = 3'd5
   } mode_e;

   typedef enum logic [3:0] {
      OP_NOP,
      OP_RUN,
      OP_STOP,
      OP_DOZE,
      OP_SLEEP,
      OP_NEWF,
      OP_ORIGF,
      OP_OFFS,
      OP_DRV,
      OP_PJ,
      OP_BAD
   } op_e;

   function automatic op_e decode_op(input logic [7:0] code);
      case (code)
         8'h00:   return OP_NOP;
         8'h50:   return OP_RUN;
         8'h18:   return OP_STOP;
         8'h20:   return OP_DOZE;
         8'h30:   return OP_SLEEP;
         8'h0C:   return OP_NEWF;
         8'h10:   return OP_ORIGF;
         8'h3A:   return OP_OFFS;
         8'h41:   return OP_DRV;
         8'h49:   return OP_PJ;
         default: return OP_BAD;
      endcase
   endfunction

   function automatic logic [2:0] op_nargs(input op_e op);
      case (op)
         OP_NEWF: return 3'd4;
         OP_OFFS: return 3'd2;
         OP_DRV:  return 3'd1;
         OP_PJ:   return 3'd1;
         default: return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/osc_cmd_parser.sv
module osc_cmd_parser
   import osc_ctrl_pkg::*;
#(
   parameter int unsigned MAX_ARGS = 4,
   localparam int unsigned ARG_W   = 8 * MAX_ARGS,
   localparam int unsigned CNT_W   = $clog2(MAX_ARGS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             deaf,
   input  logic             byte_valid,
   input  logic [7:0]       byte_data,
   input  logic             setup_seen,
   output logic             exec_valid,
   output op_e              exec_op,
   output logic [ARG_W-1:0] exec_arg,
   output logic             cmd_err
);

   initial begin
      assert (MAX_ARGS >= 4) else $error("osc_cmd_parser: MAX_ARGS must cover the longest command");
   end

   logic             busy;
   op_e              cur_op;
   logic [CNT_W-1:0] left;
   logic [ARG_W-1:0] shreg;
   op_e              byte_op;
   logic [CNT_W-1:0] byte_cnt;
   logic [ARG_W-1:0] sh_next;

   always_comb begin
      byte_op  = decode_op(byte_data);
      byte_cnt = CNT_W'(op_nargs(byte_op));
      sh_next  = {shreg[ARG_W-9:0], byte_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         cur_op     <= OP_NOP;
         left       <= '0;
         shreg      <= '0;
         exec_valid <= 1'b0;
         exec_op    <= OP_NOP;
         exec_arg   <= '0;
         cmd_err    <= 1'b0;
      end else begin
         exec_valid <= 1'b0;
         cmd_err    <= 1'b0;
         if (deaf) begin
            busy <= 1'b0;
            left <= '0;
         end else if (setup_seen) begin
            busy <= 1'b0;
            left <= '0;
         end else if (byte_valid) begin
            if (!busy) begin
               if (byte_op == OP_BAD) begin
                  cmd_err <= 1'b1;
               end else if (byte_cnt == '0) begin
                  exec_valid <= 1'b1;
                  exec_op    <= byte_op;
               end else begin
                  busy   <= 1'b1;
                  cur_op <= byte_op;
                  left   <= byte_cnt;
               end
            end else begin
               shreg <= sh_next;
               left  <= left - 1'b1;
               if (left == CNT_W'(1)) begin
                  busy       <= 1'b0;
                  exec_valid <= 1'b1;
                  exec_op    <= cur_op;
                  exec_arg   <= sh_next;
               end
            end
         end
      end
   end

   AST_EXEC_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid |-> $past(byte_valid)) else $error("exec without byte"); // R2

   AST_DEAF_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      deaf |=> (!exec_valid && !cmd_err)) else $error("activity while deaf"); // R10

endmodule

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs
   import osc_ctrl_pkg::*;
#(
   parameter int unsigned FREQ_W      = 32,
   parameter int unsigned OFS_W       = 16,
   parameter int unsigned DRV_W       = 8,
   parameter int unsigned ARG_W       = 32,
   parameter logic [FREQ_W-1:0] DEF_FREQ = '0,
   parameter logic [DRV_W-1:0]  DEF_DRV  = '0,
   parameter logic              DEF_PJ   = 1'b0,
   parameter bit          LIVE_OFFSET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_valid,
   input  op_e               exec_op,
   input  logic [ARG_W-1:0]  exec_arg,
   input  logic              in_run,
   input  logic              apply_setup,
   input  logic              apply_resume,
   output logic [FREQ_W-1:0] base_freq,
   output logic [OFS_W-1:0]  freq_offset,
   output logic [DRV_W-1:0]  drive_sel,
   output logic              jitter_mode,
   output logic              freq_dirty
);

   initial begin
      assert (FREQ_W == ARG_W) else $error("osc_cfg_regs: base frequency must fill the argument");
      assert (OFS_W <= 16 && DRV_W <= 8) else $error("osc_cfg_regs: field wider than its argument");
   end

   logic [FREQ_W-1:0] pend_base;
   logic [OFS_W-1:0]  pend_off;
   logic              pend_pj;
   logic              live_wr;

   generate
      if (LIVE_OFFSET) begin : g_live
         assign live_wr = in_run;
      end else begin : g_defer
         assign live_wr = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_base   <= DEF_FREQ;
         pend_off    <= '0;
         pend_pj     <= DEF_PJ;
         base_freq   <= DEF_FREQ;
         freq_offset <= '0;
         drive_sel   <= DEF_DRV;
         jitter_mode <= DEF_PJ;
         freq_dirty  <= 1'b0;
      end else begin
         if (apply_setup) begin
            base_freq   <= pend_base;
            freq_offset <= pend_off;
            jitter_mode <= pend_pj;
            freq_dirty  <= 1'b0;
         end else if (apply_resume) begin
            base_freq   <= pend_base;
            freq_offset <= pend_off;
         end
         if (exec_valid) begin
            case (exec_op)
               OP_NEWF: begin
                  pend_base  <= exec_arg[FREQ_W-1:0];
                  pend_off   <= '0;
                  freq_dirty <= 1'b1;
               end
               OP_ORIGF: begin
                  pend_base  <= DEF_FREQ;
                  pend_off   <= '0;
                  freq_dirty <= 1'b1;
               end
               OP_OFFS: begin
                  pend_off <= exec_arg[OFS_W-1:0];
                  if (live_wr) freq_offset <= exec_arg[OFS_W-1:0];
               end
               OP_DRV:  drive_sel <= exec_arg[DRV_W-1:0];
               OP_PJ:   pend_pj   <= exec_arg[0];
               default: ;
            endcase
         end
      end
   end

   AST_PJ_ONLY_AT_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_setup |=> $stable(jitter_mode)) else $error("jitter mode changed outside setup"); // R9

   AST_BASE_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      !(apply_setup || apply_resume) |=> $stable(base_freq)) else $error("base changed without apply"); // R7

endmodule

// File: rtl/osc_mode_fsm.sv
module osc_mode_fsm
   import osc_ctrl_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  exec_valid,
   input  op_e   exec_op,
   input  logic  freq_dirty,
   input  logic  period_done,
   input  logic  recal_ack,
   input  logic  line_edge,
   output mode_e mode,
   output logic  clk_en,
   output logic  drive_en,
   output logic  reso_en,
   output logic  core_en,
   output logic  recal_req,
   output logic  deaf,
   output logic  apply_setup,
   output logic  apply_resume
);

   mode_e state, nxt, target, nxt_tgt;

   always_comb begin
      nxt          = state;
      nxt_tgt      = target;
      apply_setup  = 1'b0;
      apply_resume = 1'b0;
      case (state)
         M_RUN: if (exec_valid) begin
            case (exec_op)
               OP_STOP:  begin nxt = M_DRAIN; nxt_tgt = M_STOP;  end
               OP_DOZE:  begin nxt = M_DRAIN; nxt_tgt = M_DOZE;  end
               OP_SLEEP: begin nxt = M_DRAIN; nxt_tgt = M_SLEEP; end
               OP_RUN, OP_NEWF, OP_ORIGF: begin
                  nxt     = M_DRAIN;
                  nxt_tgt = M_SETUP;
               end
               default: ;
            endcase
         end
         M_DRAIN: if (period_done) begin
            nxt         = target;
            apply_setup = (target == M_SETUP);
         end
         M_SETUP: if (recal_ack) nxt = M_RUN;
         M_STOP, M_DOZE: if (exec_valid) begin
            case (exec_op)
               OP_RUN: begin
                  if (freq_dirty) begin
                     nxt         = M_SETUP;
                     apply_setup = 1'b1;
                  end else begin
                     nxt          = M_RUN;
                     apply_resume = 1'b1;
                  end
               end
               OP_STOP:  nxt = M_STOP;
               OP_DOZE:  nxt = M_DOZE;
               OP_SLEEP: nxt = M_SLEEP;
               default: ;
            endcase
         end
         M_SLEEP: if (line_edge) begin
            nxt          = M_RUN;
            apply_resume = 1'b1;
         end
         default: nxt = M_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= M_RUN;
         target <= M_STOP;
      end else begin
         state  <= nxt;
         target <= nxt_tgt;
      end
   end

   always_comb begin
      mode      = state;
      clk_en    = (state == M_RUN);
      drive_en  = (state == M_RUN) || (state == M_DRAIN);
      reso_en   = (state != M_DOZE) && (state != M_SLEEP);
      core_en   = (state != M_SLEEP);
      recal_req = (state == M_SETUP);
      deaf      = (state == M_SLEEP);
   end

   AST_SETUP_EXITS_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == M_SETUP) |=> (state == M_SETUP || state == M_RUN)) else $error("setup left to non-run"); // R11

   AST_TRISTATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_en) |-> $past(period_done)) else $error("driver dropped mid-period"); // R5

   AST_CLK_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en) |-> ($past(recal_ack) || $past(exec_valid) || $past(line_edge))) else $error("clock enable rose without cause"); // R6

   AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == M_SLEEP && line_edge) |=> (state == M_RUN)) else $error("edge did not wake"); // R10

endmodule

// File: rtl/osc_mode_ctrl.sv
module osc_mode_ctrl
   import osc_ctrl_pkg::*;
#(
   parameter int unsigned FREQ_W      = 32,
   parameter int unsigned OFS_W       = 16,
   parameter int unsigned DRV_W       = 8,
   parameter int unsigned MAX_ARGS    = 4,
   parameter logic [FREQ_W-1:0] DEF_FREQ = 32'h4BBE_BC20,
   parameter logic [DRV_W-1:0]  DEF_DRV  = 8'h03,
   parameter logic              DEF_PJ   = 1'b0,
   parameter bit          LIVE_OFFSET = 1'b1,
   localparam int unsigned ARG_W      = 8 * MAX_ARGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_setup,
   input  logic              line_edge,
   input  logic              period_done,
   input  logic              recal_ack,
   output logic              clk_en,
   output logic              out_drive,
   output logic              reso_en,
   output logic              core_en,
   output logic              recal_req,
   output logic [2:0]        mode_code,
   output logic [FREQ_W-1:0] base_freq,
   output logic [OFS_W-1:0]  freq_offset,
   output logic [DRV_W-1:0]  drive_sel,
   output logic              jitter_mode,
   output logic              cmd_error
);

   logic             exec_valid;
   op_e              exec_op;
   logic [ARG_W-1:0] exec_arg;
   logic             deaf;
   logic             freq_dirty;
   logic             apply_setup;
   logic             apply_resume;
   mode_e            mode;

   osc_cmd_parser #(.MAX_ARGS(MAX_ARGS)) u_parser (
      .clk        (clk),
      .rst_n      (rst_n),
      .deaf       (deaf),
      .byte_valid (rx_valid),
      .byte_data  (rx_byte),
      .setup_seen (rx_setup),
      .exec_valid (exec_valid),
      .exec_op    (exec_op),
      .exec_arg   (exec_arg),
      .cmd_err    (cmd_error)
   );

   osc_cfg_regs #(
      .FREQ_W      (FREQ_W),
      .OFS_W       (OFS_W),
      .DRV_W       (DRV_W),
      .ARG_W       (ARG_W),
      .DEF_FREQ    (DEF_FREQ),
      .DEF_DRV     (DEF_DRV),
      .DEF_PJ      (DEF_PJ),
      .LIVE_OFFSET (LIVE_OFFSET)
   ) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .exec_valid   (exec_valid),
      .exec_op      (exec_op),
      .exec_arg     (exec_arg),
      .in_run       (mode == M_RUN),
      .apply_setup  (apply_setup),
      .apply_resume (apply_resume),
      .base_freq    (base_freq),
      .freq_offset  (freq_offset),
      .drive_sel    (drive_sel),
      .jitter_mode  (jitter_mode),
      .freq_dirty   (freq_dirty)
   );

   osc_mode_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .exec_valid   (exec_valid),
      .exec_op      (exec_op),
      .freq_dirty   (freq_dirty),
      .period_done  (period_done),
      .recal_ack    (recal_ack),
      .line_edge    (line_edge),
      .mode         (mode),
      .clk_en       (clk_en),
      .drive_en     (out_drive),
      .reso_en      (reso_en),
      .core_en      (core_en),
      .recal_req    (recal_req),
      .deaf         (deaf),
      .apply_setup  (apply_setup),
      .apply_resume (apply_resume)
   );

   assign mode_code = mode;

endmodule

// File: tb/osc_mode_ctrl_test.sv
module osc_mode_ctrl_test;

   localparam logic [31:0] DEF_F = 32'h4BBE_BC20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic rx_setup = 1'b0;
   logic line_edge = 1'b0;
   logic period_done = 1'b0;
   logic recal_ack = 1'b0;

   logic clk_en, out_drive, reso_en, core_en, recal_req, jitter_mode, cmd_error;
   logic [2:0]  mode_code;
   logic [31:0] base_freq;
   logic [15:0] freq_offset;
   logic [7:0]  drive_sel;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   osc_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_setup(rx_setup), .line_edge(line_edge), .period_done(period_done),
      .recal_ack(recal_ack), .clk_en(clk_en), .out_drive(out_drive),
      .reso_en(reso_en), .core_en(core_en), .recal_req(recal_req),
      .mode_code(mode_code), .base_freq(base_freq), .freq_offset(freq_offset),
      .drive_sel(drive_sel), .jitter_mode(jitter_mode), .cmd_error(cmd_error)
   );

   always #5 clk = ~clk;

   // {code[7:0], mode[3:0], drive, reso, core, wake_by_edge}
   localparam logic [15:0] VEC [0:2] = '{16'h1836, 16'h2042, 16'h3051};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic pd();
      @(negedge clk); period_done = 1'b1;
      @(negedge clk); period_done = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk); recal_ack = 1'b1;
      @(negedge clk); recal_ack = 1'b0;
   endtask

   task automatic wake();
      @(negedge clk); line_edge = 1'b1;
      @(negedge clk); line_edge = 1'b0;
   endtask

   task automatic setup_pulse();
      @(negedge clk); rx_setup = 1'b1;
      @(negedge clk); rx_setup = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mode", mode_code, 0);
      chk("R1 enables", {clk_en, out_drive, reso_en, core_en, recal_req}, 5'b11110);
      chk("R1 base", base_freq, DEF_F);
      chk("R1 offset", freq_offset, 0);
      chk("R1 drive", drive_sel, 8'h03);
      chk("R1 jitter", jitter_mode, 0);

      // R5 table walk: stop / doze / sleep and back to run
      for (int i = 0; i < 3; i++) begin
         send(VEC[i][15:8]);
         @(negedge clk);
         chk("R5 drain mode", mode_code, 1);
         chk("R5 drain clk/drive", {clk_en, out_drive}, 2'b01);
         pd();
         chk("R5 target mode", mode_code, VEC[i][7:4]);
         chk("R5 enables", {clk_en, out_drive, reso_en, core_en}, {1'b0, VEC[i][3:1]});
         if (VEC[i][0]) begin
            wake();
         end else begin
            send(8'h50);
            @(negedge clk);
         end
         chk("R5 back to run", {mode_code, clk_en}, {3'd0, 1'b1});
      end

      // R12 drive strength immediate
      send(8'h41); send(8'h07);
      @(negedge clk);
      chk("R12 drive", drive_sel, 8'h07);

      // R4 unknown code
      send(8'h77);
      chk("R4 err pulse", cmd_error, 1);
      @(negedge clk);
      chk("R4 err one cycle", cmd_error, 0);
      chk("R4 no change", {mode_code, drive_sel}, {3'd0, 8'h07});

      // R2 partial new-frequency: no effect yet
      send(8'h0C); send(8'h4B); send(8'h00);
      @(negedge clk);
      chk("R2 partial no action", {mode_code, base_freq}, {3'd0, DEF_F});
      // R3 setup pulse discards, next byte is a fresh code
      setup_pulse();
      send(8'h41); send(8'h09);
      @(negedge clk);
      chk("R3 fresh command", drive_sel, 8'h09);
      chk("R3 partial dropped", {mode_code, base_freq}, {3'd0, DEF_F});

      // R8 offset live in run, absolute
      send(8'h3A); send(8'h01); send(8'h23);
      @(negedge clk);
      chk("R8 live offset", freq_offset, 16'h0123);
      send(8'h3A); send(8'h00); send(8'h05);
      @(negedge clk);
      chk("R8 absolute", freq_offset, 16'h0005);

      // R6 new frequency in run
      send(8'h0C); send(8'h4B); send(8'h00); send(8'h00); send(8'h00);
      @(negedge clk);
      chk("R6 drain", {mode_code, base_freq}, {3'd1, DEF_F});
      pd();
      chk("R6 setup", {mode_code, recal_req, clk_en}, {3'd2, 2'b10});
      chk("R6 base", base_freq, 32'h4B00_0000);
      chk("R6 offset cleared", freq_offset, 0);
      // R11 mode command ignored in setup
      send(8'h18);
      @(negedge clk);
      chk("R11 still setup", mode_code, 2);
      ack();
      chk("R6 run after ack", {mode_code, clk_en, recal_req}, {3'd0, 2'b10});

      // R9 power/jitter pending until setup
      send(8'h49); send(8'h01);
      @(negedge clk);
      chk("R9 pending", jitter_mode, 0);
      send(8'h50);
      @(negedge clk);
      chk("R9 run-in-run drains", {mode_code, jitter_mode}, {3'd1, 1'b0});
      pd();
      chk("R9 applied at setup", {mode_code, jitter_mode}, {3'd2, 1'b1});
      ack();

      // R7 stored in stop, last wins
      send(8'h18); pd();
      chk("R7 stop", mode_code, 3);
      send(8'h0C); send(8'h3F); send(8'h80); send(8'h00); send(8'h00);
      send(8'h0C); send(8'h40); send(8'h00); send(8'h00); send(8'h00);
      @(negedge clk);
      chk("R7 not applied", {mode_code, base_freq}, {3'd3, 32'h4B00_0000});
      send(8'h3A); send(8'h00); send(8'h10);
      @(negedge clk);
      chk("R8 deferred in stop", freq_offset, 0);
      send(8'h50);
      @(negedge clk);
      chk("R7 via setup", {mode_code, base_freq}, {3'd2, 32'h4000_0000});
      chk("R8 applied", freq_offset, 16'h0010);
      ack();

      // R8 resume path without frequency change
      send(8'h20); pd();
      send(8'h3A); send(8'h00); send(8'h22);
      @(negedge clk);
      chk("R8 held in doze", freq_offset, 16'h0010);
      send(8'h50);
      @(negedge clk);
      chk("R8 resume", {mode_code, clk_en, freq_offset}, {3'd0, 1'b1, 16'h0022});

      // R10 sleep is deaf, edge wakes with retained config
      send(8'h30); pd();
      chk("R10 sleep", mode_code, 5);
      send(8'h41); send(8'h55);
      send(8'h77);
      chk("R10 no err", cmd_error, 0);
      @(negedge clk);
      chk("R10 drive kept", drive_sel, 8'h09);
      wake();
      chk("R10 woke", {mode_code, clk_en}, {3'd0, 1'b1});
      chk("R10 retained", {base_freq, freq_offset, jitter_mode}, {32'h4000_0000, 16'h0022, 1'b1});

      // R6 factory frequency in run
      send(8'h10);
      @(negedge clk);
      chk("R6 orig drain", mode_code, 1);
      pd();
      chk("R6 orig base", {mode_code, base_freq, freq_offset}, {3'd2, DEF_F, 16'h0000});
      ack();
      chk("R6 orig run", {mode_code, clk_en}, {3'd0, 1'b1});

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule